// File: doc/BRIEF.md
# Size-Aware General-Purpose Register File

This block holds sixteen 64-bit general-purpose registers with two combinational read ports and one write port. Each write carries a destination index, a 64-bit result and a two-bit operand-size code. A merge stage builds the new entry value from that code: a full-width write replaces the entry, a 32-bit write zero-fills the upper half, and the narrow 8-bit and 16-bit writes patch only their low lane and keep the rest of the old contents.

Only the narrow writes need the destination's previous contents, so the block flags them on a dedicated output. A rename or scoreboard stage downstream can use this flag to record a true dependency on the destination. For 32-bit and 64-bit writes the flag stays low, and those writes can issue without waiting for the older value. A read that targets the entry being written in the same cycle receives the merged new value. A synchronous reset clears every entry.

Top module: `gprf_top`

## Requirements
- R1: With `wr_size` = 2'b11 (64-bit), an enabled write replaces all 64 bits of the destination entry with `wr_data`.
- R2: With `wr_size` = 2'b10 (32-bit), an enabled write stores `wr_data[31:0]` in bits 31:0 and zero in bits 63:32, whatever the entry held before.
- R3: With `wr_size` = 2'b01 (16-bit), an enabled write stores `wr_data[15:0]` in bits 15:0 and leaves bits 63:16 unchanged.
- R4: With `wr_size` = 2'b00 (8-bit), an enabled write stores `wr_data[7:0]` in bits 7:0 and leaves bits 63:8 unchanged.
- R5: `wr_needs_old` is high in a cycle exactly when `wr_en` is high and `wr_size` is 2'b00 or 2'b01. It is low for 2'b10 and 2'b11.
- R6: A narrow write whose top result bit is set does not sign-extend. The upper bits of the entry change only through a 32-bit or 64-bit write.
- R7: When a read index equals `wr_idx` while an enabled write is in progress and reset is low, that read port returns the merged new value in the same cycle. Each read port forwards on its own.
- R8: While `rst` is high at a rising edge, every entry is cleared to zero, and an enabled write in that cycle is discarded.
- R9: While `wr_en` is low, no entry changes and `wr_needs_old` is low.
- R10: A read port whose index differs from any write in progress returns the stored contents of the addressed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Destination entry index |
| wr_data | input | 64 | Result to be merged |
| wr_size | input | 2 | Operand size: 00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit |
| wr_needs_old | output | 1 | High when the write merges with the old entry value |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_data | output | 64 | Read port 0 data |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_data | output | 64 | Read port 1 data |

## Verification
The assertions check on every cycle the properties visible within a single cycle or across one edge. These are the zero upper half and the exact lane contents of a forwarded 32-bit, 64-bit or 8-bit write, the relation between the dependency flag, the enable and the size code, and the all-zero reads right after reset. Keeping old upper bits across narrow writes, the absence of sign extension, and isolation between entries can be seen only over sequences of writes. The bench covers these by seeding entries with nonzero upper patterns and comparing every read against its own register model under random and directed traffic.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

    localparam int XLEN  = 64;
    localparam int NREGS = 16;
    localparam int IDX_W = $clog2(NREGS);
    localparam int NRD   = 2;
    localparam int W8    = 8;
    localparam int W16   = 16;
    localparam int W32   = 32;

    typedef enum logic [1:0] {
        OPS_B8  = 2'b00,
        OPS_B16 = 2'b01,
        OPS_B32 = 2'b10,
        OPS_B64 = 2'b11
    } opsize_e;

    typedef struct packed {
        logic             fire;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  value;
    } commit_t;

    // Narrow sizes patch a lane of the old value; wider ones do not read it.
    function automatic logic size_reads_old(opsize_e sz);
        return (sz == OPS_B8) || (sz == OPS_B16);
    endfunction

    function automatic logic [XLEN-1:0] merge_lane(
        logic [XLEN-1:0] prior,
        logic [XLEN-1:0] res,
        opsize_e         sz
    );
        logic [XLEN-1:0] m;
        m = prior;
        unique case (sz)
            OPS_B8:  m[W8-1:0]  = res[W8-1:0];
            OPS_B16: m[W16-1:0] = res[W16-1:0];
            OPS_B32: m = {{(XLEN-W32){1'b0}}, res[W32-1:0]};
            default: m = res;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gprf_merge.sv
module gprf_merge
    import gprf_pkg::*;
(
    input  logic             en,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  res,
    input  opsize_e          sz,
    input  logic [XLEN-1:0]  prior,
    output commit_t          commit,
    output logic             needs_old
);
    always_comb begin
        commit.fire  = en & ~rst;
        commit.idx   = idx;
        commit.value = merge_lane(prior, res, sz);
        needs_old    = en & size_reads_old(sz);
    end
endmodule

// File: rtl/gprf_storage.sv
module gprf_storage
    import gprf_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  commit_t                     commit,
    input  logic [IDX_W-1:0]            prior_idx,
    output logic [XLEN-1:0]             prior,
    output logic [NREGS-1:0][XLEN-1:0]  ent_q
);
    for (genvar e = 0; e < NREGS; e++) begin : g_ent
        logic hit;
        assign hit = commit.fire && (commit.idx == IDX_W'(e));
        always_ff @(posedge clk) begin
            if (rst)
                ent_q[e] <= '0;
            else if (hit)
                ent_q[e] <= commit.value;
        end
    end

    assign prior = ent_q[prior_idx];
endmodule

// File: rtl/gprf_rdport.sv
module gprf_rdport
    import gprf_pkg::*;
(
    input  logic [IDX_W-1:0]            idx,
    input  logic [NREGS-1:0][XLEN-1:0]  ent_q,
    input  commit_t                     commit,
    output logic [XLEN-1:0]             data
);
    always_comb begin
        if (commit.fire && (commit.idx == idx))
            data = commit.value;
        else
            data = ent_q[idx];
    end
endmodule

// File: rtl/gprf_top.sv
module gprf_top
    import gprf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [1:0]       wr_size,
    output logic             wr_needs_old,
    input  logic [IDX_W-1:0] rd0_idx,
    output logic [XLEN-1:0]  rd0_data,
    input  logic [IDX_W-1:0] rd1_idx,
    output logic [XLEN-1:0]  rd1_data
);
    commit_t                    commit;
    logic [XLEN-1:0]            prior;
    logic [NREGS-1:0][XLEN-1:0] ent_q;
    logic [NRD-1:0][IDX_W-1:0]  rd_idx;
    logic [NRD-1:0][XLEN-1:0]   rd_data;

    gprf_merge u_merge (
        .en        (wr_en),
        .rst       (rst),
        .idx       (wr_idx),
        .res       (wr_data),
        .sz        (opsize_e'(wr_size)),
        .prior     (prior),
        .commit    (commit),
        .needs_old (wr_needs_old)
    );

    gprf_storage u_store (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .prior_idx (wr_idx),
        .prior     (prior),
        .ent_q     (ent_q)
    );

    assign rd_idx[0] = rd0_idx;
    assign rd_idx[1] = rd1_idx;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        gprf_rdport u_rd (
            .idx    (rd_idx[p]),
            .ent_q  (ent_q),
            .commit (commit),
            .data   (rd_data[p])
        );
    end

    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];
endmodule

// File: rtl/gprf_chk.sv
module gprf_chk
    import gprf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [XLEN-1:0]  wr_data,
    input logic [1:0]       wr_size,
    input logic             wr_needs_old,
    input logic [IDX_W-1:0] rd0_idx,
    input logic [XLEN-1:0]  rd0_data,
    input logic [IDX_W-1:0] rd1_idx,
    input logic [XLEN-1:0]  rd1_data
);
    logic fwd0, fwd1;
    assign fwd0 = wr_en && !rst && (rd0_idx == wr_idx);
    assign fwd1 = wr_en && !rst && (rd1_idx == wr_idx);

    // R1
    full_write_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd0 && wr_size == 2'b11) |-> (rd0_data == wr_data));

    // R2
    upper_zero_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd0 && wr_size == 2'b10) |-> (rd0_data == {32'h0, wr_data[31:0]}));

    // R4
    byte_lane_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd1 && wr_size == 2'b00) |-> (rd1_data[7:0] == wr_data[7:0]));

    // R3
    half_lane_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd1 && wr_size == 2'b01) |-> (rd1_data[15:0] == wr_data[15:0]));

    // R5
    wide_no_dep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size[1]) |-> !wr_needs_old);

    // R9
    dep_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        wr_needs_old |-> wr_en);

    // R8
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_en) |-> (rd0_data == '0 && rd1_data == '0));
endmodule

bind gprf_top gprf_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .wr_size      (wr_size),
    .wr_needs_old (wr_needs_old),
    .rd0_idx      (rd0_idx),
    .rd0_data     (rd0_data),
    .rd1_idx      (rd1_idx),
    .rd1_data     (rd1_data)
);

// File: tb/tb_gprf_top.sv
module tb_gprf_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [63:0] wr_data;
    logic [1:0]  wr_size;
    logic        wr_needs_old;
    logic [3:0]  rd0_idx, rd1_idx;
    logic [63:0] rd0_data, rd1_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [63:0] model [16];

    always #5 clk = ~clk;

    gprf_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_size(wr_size), .wr_needs_old(wr_needs_old),
        .rd0_idx(rd0_idx), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_data(rd1_data)
    );

    function automatic logic [63:0] ref_merge(logic [63:0] old, logic [63:0] d, logic [1:0] s);
        case (s)
            2'b00:   return {old[63:8], d[7:0]};
            2'b01:   return {old[63:16], d[15:0]};
            2'b10:   return {32'h0, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic string size_tag(logic [1:0] s);
        case (s)
            2'b00:   return "R4";
            2'b01:   return "R3";
            2'b10:   return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check combinational outputs, then commit.
    task automatic cycle(logic en, logic [3:0] wi, logic [63:0] wd, logic [1:0] ws,
                         logic [3:0] r0, logic [3:0] r1);
        logic [63:0] nv;
        @(negedge clk);
        wr_en = en; wr_idx = wi; wr_data = wd; wr_size = ws;
        rd0_idx = r0; rd1_idx = r1;
        #1;
        nv = ref_merge(model[wi], wd, ws);
        check(en ? "R5" : "R9", {63'h0, wr_needs_old}, {63'h0, en && !ws[1]});
        if (en && r0 == wi) check("R7", rd0_data, nv);
        else                check("R10", rd0_data, model[r0]);
        if (en && r1 == wi) check("R7", rd1_data, nv);
        else                check("R10", rd1_data, model[r1]);
        @(posedge clk);
        if (en) model[wi] = nv;
    endtask

    // Write then read back the entry on the next cycle.
    task automatic wr_and_see(string tag, logic [3:0] wi, logic [63:0] wd, logic [1:0] ws);
        logic [63:0] exp;
        exp = ref_merge(model[wi], wd, ws);
        cycle(1'b1, wi, wd, ws, wi ^ 4'h1, wi ^ 4'h2);
        @(negedge clk);
        wr_en = 1'b0; rd0_idx = wi;
        #1;
        check(tag, rd0_data, exp);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; wr_size = '0;
        rd0_idx = '0; rd1_idx = '0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        // R8: a write during reset is discarded
        @(negedge clk); wr_en = 1'b1; wr_idx = 4'd3; wr_data = '1; wr_size = 2'b11;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            rd0_idx = 4'(i); rd1_idx = 4'(15 - i); #1;
            check("R8", rd0_data, 64'h0);
            check("R8", rd1_data, 64'h0);
        end
        @(posedge clk);

        // Seed entries with nonzero upper patterns, then each size.
        for (int i = 0; i < 4; i++)
            cycle(1'b1, 4'(i), 64'hA5A5_F00D_DEAD_BEEF ^ 64'(i), 2'b11, 4'(i), 4'(i + 8));
        wr_and_see("R1", 4'd0, 64'h0123_4567_89AB_CDEF, 2'b11);
        wr_and_see("R2", 4'd1, 64'hFFFF_FFFF_8000_0001, 2'b10);
        wr_and_see("R3", 4'd2, 64'h0000_0000_0000_8001, 2'b01);
        wr_and_see("R4", 4'd3, 64'h0000_0000_0000_00FF, 2'b00);
        // R6: negative narrow results leave upper bits untouched
        cycle(1'b1, 4'd5, 64'h0, 2'b11, 4'd5, 4'd6);
        wr_and_see("R6", 4'd5, 64'h0000_0000_0000_0080, 2'b00);
        wr_and_see("R6", 4'd5, 64'hFFFF_FFFF_FFFF_F000, 2'b01);
        // R9: disabled write changes nothing and raises no dependency
        cycle(1'b0, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 4'd0, 4'd1);
        @(negedge clk); rd0_idx = 4'd0; #1;
        check("R9", rd0_data, model[0]);
        @(posedge clk);
        // R7: both ports forward the same write
        cycle(1'b1, 4'd7, 64'h1111_2222_3333_4444, 2'b10, 4'd7, 4'd7);

        for (int k = 0; k < 600; k++) begin
            logic [3:0] wi;
            wi = 4'($urandom_range(0, 15));
            cycle($urandom_range(0, 7) != 0, wi,
                  {$urandom, $urandom}, 2'($urandom_range(0, 3)),
                  ($urandom_range(0, 2) == 0) ? wi : 4'($urandom_range(0, 15)),
                  ($urandom_range(0, 2) == 0) ? wi : 4'($urandom_range(0, 15)));
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); wr_en = 1'b0; rd1_idx = 4'(i); #1;
            check("R10", rd1_data, model[i]);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule